// File: doc/BRIEF.md
# Two-Rail Level-Encoded Word Serializer (Transmit Side)

This block takes a parallel word through a simple load request and sends it over two wires, a state rail and a phase rail, using a two-phase non-return-to-zero level-encoded dual-rail code. Each transmitted bit costs exactly one transition on exactly one of the two rails. There is no spacer between bits, so a receiver recovers timing from the transitions themselves. The model is synchronous: one clock cycle stands for one symbol time.

Inside, the word is split by bit index. Even-indexed stream positions go to one parallel-loaded shift register and odd-indexed positions to another. Each register advances only on every second symbol, so it runs at half the symbol rate. A merge stage picks the two heads in turn and drives the rails. Every word starts with a start bit of 1, followed by the data least significant bit first. The word length is either the short (16-bit) or the long (64-bit) length, chosen when the word is loaded. After the last bit the transmitter holds its rails and waits for one acknowledge for the whole word before it will accept another load.

Top module: `ledr_serializer_tx`

## Requirements
- R1: After each symbol, `rail_s` equals the value of the bit just sent.
- R2: `rail_p` equals the bit sent when the running symbol count since reset is odd, and its complement when that count is even. The count starts at even (0) after reset and carries across word boundaries.
- R3: Every sent symbol changes exactly one of `rail_s` and `rail_p`. In cycles with no symbol both rails hold.
- R4: A word accepted at clock edge k is sent on edges k+1 onward. The first symbol is a start bit of value 1, followed by `ld_word[0]`, `ld_word[1]`, and so on.
- R5: With `wide_mode`=1 at load, 64 data bits follow the start bit. With `wide_mode`=0, 16 data bits follow and `ld_word[63:16]` has no effect.
- R6: `ld_req` is taken only while `busy` is 0. A request while busy has no effect: no extra word is sent and no request is queued.
- R7: `busy` rises on the edge that accepts a load. It stays high until `word_ack` is seen on an edge after the last symbol has been sent. An acknowledge while symbols are still being sent is ignored.
- R8: During reset both rails are 0, `busy` is 0 and the symbol parity is even.
- R9: The length of a word is fixed when it is loaded. Changing `wide_mode` while a word is in flight does not change that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load request for `ld_word` |
| ld_word | input | 64 | Parallel data word, bit 0 sent first |
| wide_mode | input | 1 | 1 selects 64-bit words, 0 selects 16-bit words |
| word_ack | input | 1 | Word-level acknowledge from the receiver |
| busy | output | 1 | High from load until the word is acknowledged |
| rail_s | output | 1 | State rail |
| rail_p | output | 1 | Phase rail |

## Verification
The bench builds the block with its default sizes: a 64-bit maximum word and a 16-bit short word. Short words carry 17 symbols, an odd count, so the alignment between the word-local index and the global phase parity flips from one word to the next. This puts both alignments of the even and odd registers against the phase rule within reach. Long words run the half-rate registers to their full depth.

// File: rtl/ledr_tx_pkg.sv
package ledr_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

  // Phase rail value: plain bit on odd symbol parity, inverted on even.
  function automatic logic phase_of(input logic bit_val, input logic odd_parity);
    return odd_parity ? bit_val : ~bit_val;
  endfunction

  // Index of the final symbol of a word (start bit sits at index 0).
  function automatic int unsigned last_slot(input logic wide, input int unsigned short_w,
                                            input int unsigned long_w);
    return wide ? long_w : short_w;
  endfunction

endpackage

// File: rtl/ledr_half_sr.sv
module ledr_half_sr #(
  parameter int unsigned DEPTH = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DEPTH-1:0] load_vec,
  input  logic             advance,
  output logic             head
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (load) begin
      bits_q <= load_vec;
    end else if (advance) begin
      bits_q <= {1'b0, bits_q[DEPTH-1:1]};
    end
  end

  assign head = bits_q[0];

endmodule

// File: rtl/ledr_tx_ctrl.sv
module ledr_tx_ctrl
  import ledr_tx_pkg::*;
#(
  parameter int unsigned MAX_W   = 64,
  parameter int unsigned SHORT_W = 16,
  localparam int unsigned CW     = $clog2(MAX_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req,
  input  logic wide_mode,
  input  logic word_ack,
  output logic accept,
  output logic sym_fire,
  output logic slot_odd,
  output logic first_slot,
  output logic word_done,
  output logic busy
);

  tx_state_e   state_q;
  logic [CW-1:0] slot_q;
  logic          wide_q;
  logic [CW-1:0] final_slot;

  assign final_slot = CW'(last_slot(wide_q, SHORT_W, MAX_W));
  assign accept     = (state_q == TX_IDLE) && ld_req;
  assign sym_fire   = (state_q == TX_SEND);
  assign slot_odd   = slot_q[0];
  assign first_slot = sym_fire && (slot_q == '0);
  assign word_done  = sym_fire && (slot_q == final_slot);
  assign busy       = (state_q != TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      slot_q  <= '0;
      wide_q  <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (ld_req) begin
            state_q <= TX_SEND;
            slot_q  <= '0;
            wide_q  <= wide_mode;
          end
        end
        TX_SEND: begin
          if (word_done) begin
            state_q <= TX_WAIT;
          end
          slot_q <= slot_q + 1'b1;
        end
        TX_WAIT: begin
          if (word_ack) begin
            state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ledr_rail_merge.sv
module ledr_rail_merge
  import ledr_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sym_fire,
  input  logic slot_odd,
  input  logic even_head,
  input  logic odd_head,
  output logic tx_bit,
  output logic rail_s,
  output logic rail_p
);

  logic par_odd_q;

  assign tx_bit = slot_odd ? odd_head : even_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_s    <= 1'b0;
      rail_p    <= 1'b0;
      par_odd_q <= 1'b0;
    end else if (sym_fire) begin
      rail_s    <= tx_bit;
      rail_p    <= phase_of(tx_bit, par_odd_q);
      par_odd_q <= ~par_odd_q;
    end
  end

endmodule

// File: rtl/ledr_serializer_tx.sv
module ledr_serializer_tx #(
  parameter int unsigned MAX_W   = 64,
  parameter int unsigned SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic [MAX_W-1:0] ld_word,
  input  logic             wide_mode,
  input  logic             word_ack,
  output logic             busy,
  output logic             rail_s,
  output logic             rail_p
);

  localparam int unsigned EVEN_W = MAX_W / 2 + 1;
  localparam int unsigned ODD_W  = MAX_W / 2;

  logic accept, sym_fire, slot_odd, first_slot, word_done;
  logic even_head, odd_head, tx_bit;
  logic [EVEN_W-1:0] even_vec;
  logic [ODD_W-1:0]  odd_vec;

  // Stream position 0 is the start bit; position k>0 carries ld_word[k-1].
  always_comb begin
    even_vec[0] = 1'b1;
    for (int j = 1; j < EVEN_W; j++) even_vec[j] = ld_word[2*j-1];
    for (int j = 0; j < ODD_W; j++)  odd_vec[j]  = ld_word[2*j];
  end

  ledr_tx_ctrl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .wide_mode(wide_mode),
    .word_ack(word_ack), .accept(accept), .sym_fire(sym_fire),
    .slot_odd(slot_odd), .first_slot(first_slot), .word_done(word_done),
    .busy(busy)
  );

  ledr_half_sr #(.DEPTH(EVEN_W)) u_even_sr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec(even_vec),
    .advance(sym_fire && !slot_odd), .head(even_head)
  );

  ledr_half_sr #(.DEPTH(ODD_W)) u_odd_sr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec(odd_vec),
    .advance(sym_fire && slot_odd), .head(odd_head)
  );

  ledr_rail_merge u_merge (
    .clk(clk), .rst_n(rst_n), .sym_fire(sym_fire), .slot_odd(slot_odd),
    .even_head(even_head), .odd_head(odd_head), .tx_bit(tx_bit),
    .rail_s(rail_s), .rail_p(rail_p)
  );

endmodule

// File: rtl/ledr_tx_checker.sv
module ledr_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic ld_req,
  input logic word_ack,
  input logic busy,
  input logic accept,
  input logic sym_fire,
  input logic first_slot,
  input logic rail_s,
  input logic rail_p
);

  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_fire |=> ($countones({rail_s, rail_p} ^ $past({rail_s, rail_p})) == 1));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_fire |=> $stable({rail_s, rail_p}));

  p_start_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    first_slot |=> rail_s);

  p_accept_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_req));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_ack) |=> busy);

  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(word_ack) && !$past(sym_fire));

endmodule

bind ledr_serializer_tx ledr_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .word_ack(word_ack),
  .busy(busy), .accept(accept), .sym_fire(sym_fire),
  .first_slot(first_slot), .rail_s(rail_s), .rail_p(rail_p)
);

// File: tb/ledr_serializer_tx_test.sv
module ledr_serializer_tx_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0;
  logic [63:0] ld_word = '0;
  logic        wide_mode = 1'b0;
  logic        word_ack = 1'b0;
  logic        busy, rail_s, rail_p;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit q[$];
  int mstate = 0;      // 0 idle, 1 sending, 2 awaiting ack
  bit mpar = 0;        // 1 = next symbol has odd parity
  bit ms = 0, mp = 0, mbusy = 0, memit = 0;
  int changes = 0;
  bit prev_s = 0, prev_p = 0;

  ledr_serializer_tx uut (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_word(ld_word),
    .wide_mode(wide_mode), .word_ack(word_ack), .busy(busy),
    .rail_s(rail_s), .rail_p(rail_p)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    memit = 0;
    if (!rst_n) begin
      q.delete(); mstate = 0; mpar = 0; ms = 0; mp = 0; mbusy = 0;
    end else if (mstate == 2) begin
      if (word_ack) begin mstate = 0; mbusy = 0; end
    end else if (mstate == 1) begin
      bit b;
      b = q.pop_front();
      ms = b;
      mp = mpar ? b : !b;
      mpar = !mpar;
      memit = 1;
      if (q.size() == 0) mstate = 2;
    end else if (ld_req) begin
      int n;
      n = wide_mode ? 64 : 16;
      q.push_back(1'b1);
      for (int i = 0; i < n; i++) q.push_back(ld_word[i]);
      mstate = 1; mbusy = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rail_s == ms, "R1 rail_s", rail_s, ms);
      check(rail_p == mp, "R2 rail_p", rail_p, mp);
      check(busy == mbusy, "R7 busy", busy, mbusy);
      if (memit)
        check((rail_s ^ prev_s) + (rail_p ^ prev_p) == 1, "R3 one toggle",
              (rail_s ^ prev_s) + (rail_p ^ prev_p), 1);
      if (rail_s != prev_s || rail_p != prev_p) changes++;
    end
    prev_s = rail_s;
    prev_p = rail_p;
  end

  task automatic send_word(input logic [63:0] data, input bit wide, input bit early_ack,
                           input bit stray_load, input int ack_delay);
    int nbits;
    nbits = wide ? 65 : 17;
    @(negedge clk);
    ld_word = data; wide_mode = wide; ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    changes = 0;
    check(busy == 1'b1, "R7 busy after load", busy, 1);
    wide_mode = !wide;                        // R9: flip mode mid-word
    @(negedge clk);
    check(rail_s == 1'b1, "R4 start bit", rail_s, 1);
    if (early_ack) word_ack = 1'b1;           // R7: ignored while sending
    if (stray_load) begin ld_req = 1'b1; ld_word = ~data; end  // R6
    @(negedge clk);
    word_ack = 1'b0; ld_req = 1'b0;
    while (mstate != 2) @(negedge clk);
    @(negedge clk);
    check(changes == nbits, "R5 R9 symbol count", changes, nbits);
    repeat (ack_delay) @(negedge clk);
    check(busy == 1'b1, "R7 busy held awaiting ack", busy, 1);
    word_ack = 1'b1;
    @(negedge clk);
    word_ack = 1'b0;
    check(busy == 1'b0, "R7 busy cleared by ack", busy, 0);
    changes = 0;
    repeat (3) @(negedge clk);
    check(changes == 0 && !busy, "R6 no queued word", changes, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rail_s == 0 && rail_p == 0, "R8 rails in reset", {rail_s, rail_p}, 0);
    check(busy == 0, "R8 busy in reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send_word(64'hDEAD_BEEF_1234_A5C3, 1'b0, 1'b1, 1'b1, 2);
    send_word(64'hF0E1_D2C3_B4A5_9687, 1'b1, 1'b0, 1'b0, 0);
    send_word(64'h0, 1'b0, 1'b0, 1'b1, 1);
    send_word(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 3);
    send_word(64'h0123_4567_89AB_6C3E, 1'b0, 1'b1, 1'b1, 0);
    send_word(64'h5555_AAAA_3333_CCCC, 1'b1, 1'b0, 1'b1, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule